// File: doc/BRIEF.md
# Processor Status Register Unit

This block keeps the eight-bit status word of a small microcontroller core. It stores the arithmetic flags written back by the ALU, a one-bit transfer cell used to move single bits between registers, and the global interrupt enable that decides whether any interrupt request may reach the core. The sign flag is never stored: it is always produced from the negative and overflow flags.

The instruction decoder drives one-cycle strobes for interrupt entry, return from interrupt, interrupt enable, interrupt disable, bit store and bit load. The ALU supplies five flag results, each with its own write enable. Software can also overwrite the whole word through a memory-mapped write port. All state changes take effect at the rising clock edge after the strobe. The interrupt request output, the sign flag and the bit-load result byte are combinational views of the stored state and the current inputs.

Top module: `psr_unit`

## Requirements
- R1: After reset every bit of `status_o` is 0. The word is laid out with the interrupt enable at bit 7, the transfer bit at bit 6, half carry at bit 5, sign at bit 4, overflow at bit 3, negative at bit 2, zero at bit 1 and carry at bit 0.
- R2: `irq_req_o` is 1 exactly when the interrupt enable bit is 1 and at least one source has both its `irq_pend_i` bit and its `irq_en_i` bit set. While the enable bit is 0, `irq_req_o` stays 0 for every pending and enable pattern.
- R3: An `irq_take_i` strobe leaves the interrupt enable bit at 0 after the next edge. This holds even when any other strobe or a software write is asserted in the same cycle.
- R4: An `irq_ret_i` strobe sets the interrupt enable bit at the next edge, unless R3 or R10 decides the bit in that cycle, or `irq_clr_i` is also asserted.
- R5: `irq_set_i` sets the interrupt enable bit and `irq_clr_i` clears it at the next edge. When the clear strobe is asserted together with `irq_set_i` or `irq_ret_i`, the bit ends at 0.
- R6: A `bit_store_i` strobe copies bit `bit_idx_i` of `opnd_i` into the transfer bit (bit 6) at the next edge, unless a software write happens in the same cycle.
- R7: `bld_result_o` is `opnd_i` with bit `bit_idx_i` replaced by the stored transfer bit while `bit_load_i` is 1. It equals `opnd_i` while `bit_load_i` is 0. A bit load changes no bit of `status_o`.
- R8: The sign bit (`status_o[4]` and `sign_o`) always equals negative xor overflow from the current stored flags. It follows every ALU or software update of those flags. Data bit 4 of a software write is ignored.
- R9: Each ALU flag whose `alu_we_i` bit is set loads its `alu_flags_i` bit at the next edge, and the other flags hold their values. The index order in both vectors is 4 half carry, 3 overflow, 2 negative, 1 zero, 0 carry.
- R10: A `mmr_we_i` write loads bits 7, 6, 5, 3, 2, 1 and 0 of `mmr_wdata_i` into the same status positions at the next edge. It overrides the ALU enables, bit store, set, clear and return in the same cycle, but not interrupt entry.
- R11: In a cycle with no strobe, no ALU write enable and no software write, `status_o` keeps its value whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_take_i | input | 1 | Interrupt entry strobe |
| irq_ret_i | input | 1 | Return-from-interrupt strobe |
| irq_set_i | input | 1 | Enable-interrupts strobe |
| irq_clr_i | input | 1 | Disable-interrupts strobe |
| bit_store_i | input | 1 | Copy a selected operand bit into the transfer bit |
| bit_load_i | input | 1 | Insert the transfer bit into the operand on `bld_result_o` |
| alu_flags_i | input | 5 | ALU flag results {H, V, N, Z, C} |
| alu_we_i | input | 5 | Per-flag write enables, same order |
| opnd_i | input | DATA_W (8) | Register-file operand |
| bit_idx_i | input | IDX_W (3) | Bit position for store and load |
| mmr_we_i | input | 1 | Software write enable |
| mmr_wdata_i | input | 8 | Software write data |
| irq_pend_i | input | NUM_IRQ (4) | Pending interrupt sources |
| irq_en_i | input | NUM_IRQ (4) | Per-source interrupt enables |
| status_o | output | 8 | Status word |
| irq_req_o | output | 1 | Gated interrupt request to the core |
| sign_o | output | 1 | Sign flag, negative xor overflow |
| bld_result_o | output | DATA_W (8) | Operand with the transfer bit inserted |

## Verification
The bench sweeps every combination of the four interrupt strobes and the software write against both starting values of the enable bit. This catches a design that lets a simultaneous enable or write undo interrupt entry, which would reopen interrupts inside a handler. Every bit position is covered for store and load with both transfer-bit values, so a shifted index or a load that clobbers neighbouring bits shows up as a wrong result byte. All 1024 pairs of flag enable and flag value are applied, along with all 256 software write values. A sign bit that is stored instead of derived would then report a written or stale value rather than negative xor overflow. The full pending and enable product is checked with the interrupt enable both off and on, so a request that leaks past a cleared enable is caught.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int FLAG_W = 5;

    // Arithmetic flag indices inside the ALU flag vectors
    localparam int AF_C = 0;
    localparam int AF_Z = 1;
    localparam int AF_N = 2;
    localparam int AF_V = 3;
    localparam int AF_H = 4;

    // Positions in the visible status word
    localparam int SB_C = 0;
    localparam int SB_Z = 1;
    localparam int SB_N = 2;
    localparam int SB_V = 3;
    localparam int SB_S = 4;
    localparam int SB_H = 5;
    localparam int SB_T = 6;
    localparam int SB_I = 7;

    typedef struct packed {
        logic              gie;
        logic              xfer;
        logic [FLAG_W-1:0] arith;
    } psr_state_t;

    function automatic logic [7:0] psr_pack(psr_state_t s);
        logic [7:0] w;
        w       = '0;
        w[SB_I] = s.gie;
        w[SB_T] = s.xfer;
        w[SB_H] = s.arith[AF_H];
        w[SB_S] = s.arith[AF_N] ^ s.arith[AF_V];
        w[SB_V] = s.arith[AF_V];
        w[SB_N] = s.arith[AF_N];
        w[SB_Z] = s.arith[AF_Z];
        w[SB_C] = s.arith[AF_C];
        return w;
    endfunction

    function automatic logic [FLAG_W-1:0] psr_arith_of_word(logic [7:0] w);
        logic [FLAG_W-1:0] a;
        a       = '0;
        a[AF_H] = w[SB_H];
        a[AF_V] = w[SB_V];
        a[AF_N] = w[SB_N];
        a[AF_Z] = w[SB_Z];
        a[AF_C] = w[SB_C];
        return a;
    endfunction

endpackage

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
    parameter int NUM_IRQ = 4
) (
    input  logic               gie_i,
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic [NUM_IRQ-1:0] en_i,
    output logic               req_o
);

    logic [NUM_IRQ-1:0] live;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
        assign live[g] = pend_i[g] & en_i[g];
    end

    assign req_o = gie_i & (|live);

endmodule

// File: rtl/psr_bit_ops.sv
module psr_bit_ops #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              xfer_i,
    input  logic              load_i,
    output logic              pick_o,
    output logic [DATA_W-1:0] load_o
);

    assign pick_o = opnd_i[idx_i];

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign load_o[g] = (load_i && (idx_i == IDX_W'(g))) ? xfer_i : opnd_i[g];
    end

endmodule

// File: rtl/psr_flag_merge.sv
module psr_flag_merge #(
    parameter int NF = 5
) (
    input  logic [NF-1:0] cur_i,
    input  logic [NF-1:0] alu_i,
    input  logic [NF-1:0] we_i,
    input  logic          ovr_i,
    input  logic [NF-1:0] ovr_val_i,
    output logic [NF-1:0] nxt_o
);

    for (genvar g = 0; g < NF; g++) begin : g_flag
        assign nxt_o[g] = ovr_i   ? ovr_val_i[g] :
                          we_i[g] ? alu_i[g]     : cur_i[g];
    end

endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
#(
    parameter int NUM_IRQ = 4,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_take_i,
    input  logic               irq_ret_i,
    input  logic               irq_set_i,
    input  logic               irq_clr_i,
    input  logic               bit_store_i,
    input  logic               bit_load_i,
    input  logic [FLAG_W-1:0]  alu_flags_i,
    input  logic [FLAG_W-1:0]  alu_we_i,
    input  logic [DATA_W-1:0]  opnd_i,
    input  logic [IDX_W-1:0]   bit_idx_i,
    input  logic               mmr_we_i,
    input  logic [7:0]         mmr_wdata_i,
    input  logic [NUM_IRQ-1:0] irq_pend_i,
    input  logic [NUM_IRQ-1:0] irq_en_i,
    output logic [7:0]         status_o,
    output logic               irq_req_o,
    output logic               sign_o,
    output logic [DATA_W-1:0]  bld_result_o
);

    psr_state_t        state_d, state_q;
    logic [FLAG_W-1:0] arith_nxt;
    logic              picked_bit;
    logic              unused_sign_wr;

    // Sign is always derived, so the written sign bit has no destination
    assign unused_sign_wr = mmr_wdata_i[SB_S];

    psr_flag_merge #(.NF(FLAG_W)) u_merge (
        .cur_i     (state_q.arith),
        .alu_i     (alu_flags_i),
        .we_i      (alu_we_i),
        .ovr_i     (mmr_we_i),
        .ovr_val_i (psr_arith_of_word(mmr_wdata_i)),
        .nxt_o     (arith_nxt)
    );

    psr_bit_ops #(.DATA_W(DATA_W)) u_bits (
        .opnd_i (opnd_i),
        .idx_i  (bit_idx_i),
        .xfer_i (state_q.xfer),
        .load_i (bit_load_i),
        .pick_o (picked_bit),
        .load_o (bld_result_o)
    );

    psr_irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
        .gie_i  (state_q.gie),
        .pend_i (irq_pend_i),
        .en_i   (irq_en_i),
        .req_o  (irq_req_o)
    );

    always_comb begin
        state_d = state_q;

        // Interrupt enable: entry > software write > clear > set/return
        if (irq_take_i) begin
            state_d.gie = 1'b0;
        end else if (mmr_we_i) begin
            state_d.gie = mmr_wdata_i[SB_I];
        end else if (irq_clr_i) begin
            state_d.gie = 1'b0;
        end else if (irq_set_i || irq_ret_i) begin
            state_d.gie = 1'b1;
        end

        // Transfer bit: software write > bit store
        if (mmr_we_i) begin
            state_d.xfer = mmr_wdata_i[SB_T];
        end else if (bit_store_i) begin
            state_d.xfer = picked_bit;
        end

        state_d.arith = arith_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o = psr_pack(state_q);
    assign sign_o   = state_q.arith[AF_N] ^ state_q.arith[AF_V];

endmodule

// File: rtl/psr_checks.sv
module psr_checks #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_take_i,
    input logic              irq_ret_i,
    input logic              irq_set_i,
    input logic              irq_clr_i,
    input logic              bit_store_i,
    input logic              bit_load_i,
    input logic [4:0]        alu_flags_i,
    input logic [4:0]        alu_we_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [IDX_W-1:0]  bit_idx_i,
    input logic              mmr_we_i,
    input logic [7:0]        mmr_wdata_i,
    input logic [7:0]        status_o,
    input logic              irq_req_o,
    input logic              sign_o,
    input logic [DATA_W-1:0] bld_result_o
);

    p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[7] |-> !irq_req_o);

    p_take_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_i |=> !status_o[7]);

    p_ret_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ret_i && !irq_take_i && !mmr_we_i && !irq_clr_i |=> status_o[7]);

    p_set_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set_i && !irq_take_i && !mmr_we_i && !irq_clr_i |=> status_o[7]);

    p_clr_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_i && !mmr_we_i |=> !status_o[7]);

    p_store_copies_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_store_i && !mmr_we_i |=> status_o[6] == $past(opnd_i[bit_idx_i]));

    p_load_inserts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_load_i |-> bld_result_o[bit_idx_i] == status_o[6]);

    p_load_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_load_i |-> bld_result_o == opnd_i);

    p_sign_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mmr_we_i && !irq_take_i && (mmr_wdata_i[4] != (mmr_wdata_i[3] ^ mmr_wdata_i[2]))
        |=> status_o[4] == $past(mmr_wdata_i[3] ^ mmr_wdata_i[2]));

    p_alu_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mmr_we_i && alu_we_i[3] && alu_we_i[2]
        |=> sign_o == $past(alu_flags_i[3] ^ alu_flags_i[2]));

    p_alu_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mmr_we_i && (alu_we_i == 5'h1f)
        |=> {status_o[5], status_o[3:0]} == $past(alu_flags_i));

    p_write_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mmr_we_i |=> {status_o[6:5], status_o[3:0]} == $past({mmr_wdata_i[6:5], mmr_wdata_i[3:0]}));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_take_i && !irq_ret_i && !irq_set_i && !irq_clr_i && !bit_store_i
        && !mmr_we_i && (alu_we_i == '0) |=> $stable(status_o));

endmodule

bind psr_unit psr_checks #(.DATA_W(DATA_W)) u_psr_checks (.*);

// File: tb/test_psr_unit.sv
module test_psr_unit;

    localparam int NUM_IRQ = 4;
    localparam int DATA_W  = 8;
    localparam int IDX_W   = 3;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               irq_take_i, irq_ret_i, irq_set_i, irq_clr_i;
    logic               bit_store_i, bit_load_i;
    logic [4:0]         alu_flags_i, alu_we_i;
    logic [DATA_W-1:0]  opnd_i;
    logic [IDX_W-1:0]   bit_idx_i;
    logic               mmr_we_i;
    logic [7:0]         mmr_wdata_i;
    logic [NUM_IRQ-1:0] irq_pend_i, irq_en_i;
    logic [7:0]         status_o;
    logic               irq_req_o, sign_o;
    logic [DATA_W-1:0]  bld_result_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    bit  mI, mT, mH, mV, mN, mZ, mC;

    always #5 clk = ~clk;

    psr_unit #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) i_psr_unit (.*);

    function automatic logic [7:0] exp_st();
        return {mI, mT, mH, mN ^ mV, mV, mN, mZ, mC};
    endfunction

    task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic idle_in();
        irq_take_i = 0; irq_ret_i = 0; irq_set_i = 0; irq_clr_i = 0;
        bit_store_i = 0; bit_load_i = 0; alu_flags_i = '0; alu_we_i = '0;
        mmr_we_i = 0; mmr_wdata_i = '0;
    endtask

    // Reference update from the requirement text
    task automatic model_step();
        if (irq_take_i)                  mI = 0;
        else if (mmr_we_i)               mI = mmr_wdata_i[7];
        else if (irq_clr_i)              mI = 0;
        else if (irq_set_i || irq_ret_i) mI = 1;
        if (mmr_we_i)         mT = mmr_wdata_i[6];
        else if (bit_store_i) mT = opnd_i[bit_idx_i];
        if (mmr_we_i) begin
            mH = mmr_wdata_i[5]; mV = mmr_wdata_i[3]; mN = mmr_wdata_i[2];
            mZ = mmr_wdata_i[1]; mC = mmr_wdata_i[0];
        end else begin
            if (alu_we_i[4]) mH = alu_flags_i[4];
            if (alu_we_i[3]) mV = alu_flags_i[3];
            if (alu_we_i[2]) mN = alu_flags_i[2];
            if (alu_we_i[1]) mZ = alu_flags_i[1];
            if (alu_we_i[0]) mC = alu_flags_i[0];
        end
    endtask

    task automatic tick(string r);
        model_step();
        @(posedge clk);
        #1;
        chk(r, status_o, exp_st());
    endtask

    task automatic write_word(logic [7:0] w);
        idle_in();
        mmr_we_i = 1; mmr_wdata_i = w;
        tick("R10 setup write");
        idle_in();
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle_in();
        opnd_i = '0; bit_idx_i = '0; irq_pend_i = '0; irq_en_i = '0;
        {mI, mT, mH, mV, mN, mZ, mC} = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset status", status_o, 8'h00);
        chk("R1 reset irq_req", {7'b0, irq_req_o}, 8'h00);
        rst_n = 1;
        tick("R11 idle after reset");

        // R2: full pending/enable product with the enable bit off and on
        for (int g = 0; g < 2; g++) begin
            write_word({g[0], 7'h00});
            for (int p = 0; p < 16; p++) begin
                for (int e = 0; e < 16; e++) begin
                    irq_pend_i = p[3:0]; irq_en_i = e[3:0];
                    #1;
                    chk("R2 irq gating", {7'b0, irq_req_o},
                        {7'b0, mI & (|(p[3:0] & e[3:0]))});
                end
            end
        end
        irq_pend_i = '0; irq_en_i = '0;

        // R3 R4 R5 R10: every strobe combination from both enable states
        for (int g = 0; g < 2; g++) begin
            for (int s = 0; s < 32; s++) begin
                write_word({g[0], 7'h15});
                irq_take_i = s[0]; irq_ret_i = s[1]; irq_set_i = s[2];
                irq_clr_i = s[3]; mmr_we_i = s[4];
                mmr_wdata_i = {~g[0], 2'b10, s[0], 4'b0110} ^ {3'b0, s[4:0]};
                tick("R3 R4 R5 R10 enable priority");
                idle_in();
            end
        end

        // R6: bit store at every index
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] one;
                one = 8'h01 << i;
                bit_idx_i = i[2:0];
                opnd_i = (k == 0) ? 8'h00 : (k == 1) ? 8'hff : (k == 2) ? one : ~one;
                bit_store_i = 1;
                tick("R6 bit store");
                chk("R6 transfer bit", {7'b0, status_o[6]}, {7'b0, opnd_i[i]});
                idle_in();
            end
        end

        // R7: bit load at every index with both transfer values
        for (int t = 0; t < 2; t++) begin
            write_word({1'b0, t[0], 6'h2a});
            for (int i = 0; i < 8; i++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [7:0] op, want;
                    op = (k == 0) ? 8'h00 : (k == 1) ? 8'hff : 8'h5a ^ 8'(i * 37);
                    want = (op & ~(8'h01 << i)) | (8'(t) << i);
                    opnd_i = op; bit_idx_i = i[2:0];
                    bit_load_i = 0;
                    #1;
                    chk("R7 no load passes operand", bld_result_o, op);
                    bit_load_i = 1;
                    #1;
                    chk("R7 bit load result", bld_result_o, want);
                    tick("R7 load leaves status");
                    idle_in();
                end
            end
        end

        // R8 R9: every enable mask against every flag value
        for (int w = 0; w < 32; w++) begin
            for (int f = 0; f < 32; f++) begin
                alu_we_i = w[4:0]; alu_flags_i = f[4:0];
                opnd_i = 8'(f * 11);
                tick("R9 per-flag enables");
                chk("R8 sign output", {7'b0, sign_o}, {7'b0, mN ^ mV});
                idle_in();
            end
        end

        // R10 beats ALU and bit store; R8 ignores written sign bit
        for (int v = 0; v < 256; v++) begin
            mmr_we_i = 1; mmr_wdata_i = v[7:0];
            alu_we_i = 5'h1f; alu_flags_i = ~v[4:0];
            bit_store_i = 1; opnd_i = ~v[7:0]; bit_idx_i = 3'd6;
            tick("R10 write overrides");
            chk("R8 written sign ignored", {7'b0, status_o[4]}, {7'b0, v[3] ^ v[2]});
            idle_in();
        end

        // R11: data inputs toggling without any strobe
        for (int n = 0; n < 16; n++) begin
            opnd_i = 8'(n * 29); bit_idx_i = n[2:0];
            alu_flags_i = n[4:0]; mmr_wdata_i = 8'(~n);
            tick("R11 hold without strobes");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule